// File: doc/BRIEF.md
# Two-Stage System Watchdog Timer

This block is a register-mapped watchdog for a chipset management function. A down-counter advances on a slow tick strobe (one tick standing for 0.6 s of wall time). Software must rewrite a reload register before the count runs out. If it fails to, the first expiry only raises a sticky timeout flag and, if enabled, a management interrupt. The counter then restarts from its programmed start value. A second expiry while that flag is still set records a second-timeout flag and a boot flag, and emits a one-cycle reset request to the reset sequencer. A no-reboot strap input can suppress that request.

Software sees six 16-bit registers on a byte-addressed bus with write strobe, read strobe and per-byte lane enables. All flags are cleared by writing one. Clearing the first-timeout flag before the second expiry gives software a full two-period margin again. A halt control freezes the count and is set out of reset, so the watchdog stays idle until software starts it.

Top module: `wdt_twostage`

## Requirements
- R1: While running, each cycle with `tick_en` high lowers the count by one; a read of offset 0x00 returns the count in bits 9:0 with upper bits zero.
- R2: Any write to offset 0x00, whatever the data, loads the count from the start value; it takes priority over a tick in the same cycle.
- R3: Offset 0x12 holds the start value in bits 9:0; bits 15:10 are plain storage that read back as written; each byte lane is written only when its enable (bit 0 for bits 7:0, bit 1 for bits 15:8) is high.
- R4: A write that would leave a start value below 4 leaves bits 9:0 of offset 0x12 unchanged; a value of exactly 4 is taken.
- R5: Bit 11 of offset 0x08 is a halt bit, 1 after reset; while it is 1 ticks do not change the count; it reads back as written.
- R6: A tick seen at count 0 while bit 3 of offset 0x04 is clear sets that bit and reloads the count from the start value in the same edge.
- R7: A tick seen at count 0 while bit 3 of offset 0x04 is set sets bits 1 and 2 of offset 0x06, reloads the count, and drives `rst_req_o` high for exactly one cycle.
- R8: Status bits 3 at 0x04 and 1, 2 at 0x06 clear only when written with one (lane 0 enabled); writing zero leaves them; clearing bit 3 before the next expiry makes that expiry count as a first one again.
- R9: With `no_reboot` high, a second expiry still updates the status bits but `rst_req_o` stays low.
- R10: `irq_o` is high exactly while bit 3 of offset 0x04 and bit 13 of offset 0x0C (the interrupt enable) are both set.
- R11: After reset the count and start value are 20, halt is set, all status bits, the interrupt enable, `irq_o` and `rst_req_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Byte address of the register accessed |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; read data is zero when low |
| bus_be | input | 2 | Byte lane enables for writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the address |
| tick_en | input | 1 | One-cycle strobe per watchdog tick |
| no_reboot | input | 1 | Strap that blocks the reset request |
| irq_o | output | 1 | Management interrupt, level |
| rst_req_o | output | 1 | System reset request, one-cycle pulse |

## Verification
A table-driven run programs start values, kicks, halts and ticks the counter, and reads every register. It separates the decrement path, the reload-at-zero path and the frozen path by the count value read back. Directed cases then let the counter expire with the interrupt enable off and then on, clear the first flag just before a second expiry to show the two-period margin returns, and repeat a double expiry with the strap low and high. Counting reset pulses at the port tells an unconditional reset request apart from a gated one. The rejected start values 2 and 3 are contrasted with the accepted boundary value 4.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   localparam int ADDR_W = 5;
   localparam int DATA_W = 16;
   localparam int NLANES = DATA_W / 8;

   localparam logic [ADDR_W-1:0] OFS_KICK  = 5'h00;
   localparam logic [ADDR_W-1:0] OFS_FLAG1 = 5'h04;
   localparam logic [ADDR_W-1:0] OFS_FLAG2 = 5'h06;
   localparam logic [ADDR_W-1:0] OFS_CTRL  = 5'h08;
   localparam logic [ADDR_W-1:0] OFS_IEN   = 5'h0C;
   localparam logic [ADDR_W-1:0] OFS_START = 5'h12;

   localparam int B_FIRST = 3;
   localparam int B_SECOND = 1;
   localparam int B_BOOT = 2;
   localparam int B_HALT = 11;
   localparam int B_IEN = 13;

   typedef struct packed {
      logic first;
      logic second;
      logic boot;
   } wdt_flags_t;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
   import wdt_pkg::*;
#(
   parameter int CNT_W = 10,
   parameter int MIN_START = 4,
   parameter int START_RST = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              rd,
   input  logic [NLANES-1:0] be,
   input  logic [DATA_W-1:0] wdata,
   input  logic [CNT_W-1:0]  count,
   input  wdt_flags_t        flags,
   output logic [DATA_W-1:0] rdata,
   output logic [CNT_W-1:0]  start_val,
   output logic              halt,
   output logic              ien,
   output logic              kick,
   output wdt_flags_t        clr
);
   localparam int UP_W = DATA_W - CNT_W;

   logic [DATA_W-1:0] lane_mask;
   logic [DATA_W-1:0] start_q;
   logic [DATA_W-1:0] start_cand;
   logic              halt_q;
   logic              ien_q;
   logic              flag1_wr;
   logic              flag2_wr;

   for (genvar g = 0; g < NLANES; g++) begin : g_lane
      assign lane_mask[g*8 +: 8] = {8{be[g]}};
   end

   assign start_cand = (start_q & ~lane_mask) | (wdata & lane_mask);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_q <= DATA_W'(START_RST);
         halt_q  <= 1'b1;
         ien_q   <= 1'b0;
      end else if (wr) begin
         if (addr == OFS_START) begin
            if (start_cand[CNT_W-1:0] >= CNT_W'(MIN_START))
               start_q <= start_cand;
            else
               start_q <= {start_cand[DATA_W-1:CNT_W], start_q[CNT_W-1:0]};
         end
         if (addr == OFS_CTRL && lane_mask[B_HALT])
            halt_q <= wdata[B_HALT];
         if (addr == OFS_IEN && lane_mask[B_IEN])
            ien_q <= wdata[B_IEN];
      end
   end

   assign flag1_wr = wr && (addr == OFS_FLAG1);
   assign flag2_wr = wr && (addr == OFS_FLAG2);

   assign kick       = wr && (addr == OFS_KICK);
   assign clr.first  = flag1_wr && lane_mask[B_FIRST] && wdata[B_FIRST];
   assign clr.second = flag2_wr && lane_mask[B_SECOND] && wdata[B_SECOND];
   assign clr.boot   = flag2_wr && lane_mask[B_BOOT] && wdata[B_BOOT];

   assign start_val = start_q[CNT_W-1:0];
   assign halt      = halt_q;
   assign ien       = ien_q;

   always_comb begin
      rdata = '0;
      if (rd) begin
         unique case (addr)
            OFS_KICK:  rdata[CNT_W-1:0] = count;
            OFS_FLAG1: rdata[B_FIRST] = flags.first;
            OFS_FLAG2: begin
               rdata[B_SECOND] = flags.second;
               rdata[B_BOOT]   = flags.boot;
            end
            OFS_CTRL:  rdata[B_HALT] = halt_q;
            OFS_IEN:   rdata[B_IEN] = ien_q;
            OFS_START: rdata = start_q;
            default:   rdata = '0;
         endcase
      end
   end

   if (UP_W < 0) begin : g_bad_width
      $error("wdt_regs: CNT_W wider than the data bus");
   end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
   parameter int CNT_W = 10,
   parameter int START_RST = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             halt,
   input  logic             kick,
   input  logic [CNT_W-1:0] start_val,
   output logic [CNT_W-1:0] count,
   output logic             expire
);
   logic [CNT_W-1:0] cnt_q;
   logic             step;

   assign step   = tick && !halt && !kick;
   assign expire = step && (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= CNT_W'(START_RST);
      else if (kick || expire)
         cnt_q <= start_val;
      else if (step)
         cnt_q <= cnt_q - CNT_W'(1);
   end

   assign count = cnt_q;
endmodule

// File: rtl/wdt_status.sv
module wdt_status
   import wdt_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       expire,
   input  logic       no_reboot,
   input  logic       ien,
   input  wdt_flags_t clr,
   output wdt_flags_t flags,
   output logic       irq,
   output logic       rst_req
);
   wdt_flags_t fl_q;
   logic       req_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fl_q  <= '0;
         req_q <= 1'b0;
      end else begin
         req_q <= 1'b0;
         if (clr.first)  fl_q.first  <= 1'b0;
         if (clr.second) fl_q.second <= 1'b0;
         if (clr.boot)   fl_q.boot   <= 1'b0;
         if (expire) begin
            if (fl_q.first) begin
               fl_q.second <= 1'b1;
               fl_q.boot   <= 1'b1;
               req_q       <= !no_reboot;
            end else begin
               fl_q.first  <= 1'b1;
            end
         end
      end
   end

   assign flags   = fl_q;
   assign irq     = fl_q.first && ien;
   assign rst_req = req_q;
endmodule

// File: rtl/wdt_twostage.sv
module wdt_twostage
   import wdt_pkg::*;
#(
   parameter int CNT_W = 10,
   parameter int MIN_START = 4,
   parameter int START_RST = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [NLANES-1:0] bus_be,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              tick_en,
   input  logic              no_reboot,
   output logic              irq_o,
   output logic              rst_req_o
);
   logic [CNT_W-1:0] count;
   logic [CNT_W-1:0] start_val;
   logic             halt;
   logic             ien;
   logic             kick;
   logic             expire;
   wdt_flags_t       clr;
   wdt_flags_t       flags;

   if (CNT_W < 3 || CNT_W > DATA_W) begin : g_chk_w
      $error("wdt_twostage: CNT_W out of range");
   end
   if (MIN_START < 1 || MIN_START >= (1 << CNT_W)) begin : g_chk_min
      $error("wdt_twostage: MIN_START out of range");
   end
   if (START_RST < MIN_START || START_RST >= (1 << CNT_W)) begin : g_chk_rst
      $error("wdt_twostage: START_RST out of range");
   end

   wdt_regs #(.CNT_W(CNT_W), .MIN_START(MIN_START), .START_RST(START_RST)) regs_i (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
      .be(bus_be), .wdata(bus_wdata), .count(count), .flags(flags),
      .rdata(bus_rdata), .start_val(start_val), .halt(halt), .ien(ien),
      .kick(kick), .clr(clr)
   );

   wdt_counter #(.CNT_W(CNT_W), .START_RST(START_RST)) cnt_i (
      .clk(clk), .rst_n(rst_n), .tick(tick_en), .halt(halt), .kick(kick),
      .start_val(start_val), .count(count), .expire(expire)
   );

   wdt_status stat_i (
      .clk(clk), .rst_n(rst_n), .expire(expire), .no_reboot(no_reboot),
      .ien(ien), .clr(clr), .flags(flags), .irq(irq_o), .rst_req(rst_req_o)
   );
endmodule

// File: rtl/wdt_twostage_chk.sv
module wdt_twostage_chk #(
   parameter int CNT_W = 10,
   parameter int MIN_START = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_en,
   input logic             halt,
   input logic             kick,
   input logic             no_reboot,
   input logic             first,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] start_val,
   input logic             rst_req_o
);
   a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && !halt && !kick && count != '0) |=> count == $past(count) - CNT_W'(1));

   a_r2_kick_load: assert property (@(posedge clk) disable iff (!rst_n)
      kick |=> count == $past(start_val));

   a_r4_start_floor: assert property (@(posedge clk) disable iff (!rst_n)
      start_val >= CNT_W'(MIN_START));

   a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && !kick) |=> $stable(count));

   a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o |=> !rst_req_o);

   a_r7_after_first: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o |-> $past(first));

   a_r9_strap_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o |-> !$past(no_reboot));
endmodule

bind wdt_twostage wdt_twostage_chk #(.CNT_W(CNT_W), .MIN_START(MIN_START)) chk_i (
   .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .halt(halt), .kick(kick),
   .no_reboot(no_reboot), .first(flags.first), .count(count),
   .start_val(start_val), .rst_req_o(rst_req_o)
);

// File: tb/wdt_twostage_tb_top.sv
module wdt_twostage_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [1:0]  bus_be = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        tick_en = 1'b0;
   logic        no_reboot = 1'b0;
   logic        irq_o;
   logic        rst_req_o;

   int vectors = 0;
   int miscompares = 0;
   int pulses = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   wdt_twostage dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_be(bus_be), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .tick_en(tick_en), .no_reboot(no_reboot),
      .irq_o(irq_o), .rst_req_o(rst_req_o)
   );

   always @(negedge clk) if (rst_n && rst_req_o) pulses++;

   // op: 0 write, 1 read-and-compare, 2 apply data ticks
   localparam int NV = 28;
   localparam logic [40:0] VEC [NV] = '{
      {2'd0, 5'h12, 2'd3, 16'h0005, 16'h0000},
      {2'd0, 5'h00, 2'd1, 16'h0000, 16'h0000},
      {2'd1, 5'h00, 2'd0, 16'h0000, 16'h0005},  // R2
      {2'd0, 5'h08, 2'd3, 16'h0000, 16'h0000},
      {2'd2, 5'h00, 2'd0, 16'd2,    16'h0000},
      {2'd1, 5'h00, 2'd0, 16'h0000, 16'h0003},  // R1
      {2'd2, 5'h00, 2'd0, 16'd3,    16'h0000},
      {2'd1, 5'h00, 2'd0, 16'h0000, 16'h0000},  // R1
      {2'd2, 5'h00, 2'd0, 16'd1,    16'h0000},
      {2'd1, 5'h04, 2'd0, 16'h0000, 16'h0008},  // R6
      {2'd1, 5'h00, 2'd0, 16'h0000, 16'h0005},  // R6
      {2'd0, 5'h12, 2'd3, 16'h0002, 16'h0000},
      {2'd1, 5'h12, 2'd0, 16'h0000, 16'h0005},  // R4
      {2'd0, 5'h12, 2'd3, 16'hFC07, 16'h0000},
      {2'd1, 5'h12, 2'd0, 16'h0000, 16'hFC07},  // R3
      {2'd0, 5'h04, 2'd1, 16'h0000, 16'h0000},
      {2'd1, 5'h04, 2'd0, 16'h0000, 16'h0008},  // R8
      {2'd2, 5'h00, 2'd0, 16'd6,    16'h0000},
      {2'd1, 5'h06, 2'd0, 16'h0000, 16'h0006},  // R7
      {2'd1, 5'h00, 2'd0, 16'h0000, 16'h0007},  // R7
      {2'd0, 5'h06, 2'd1, 16'h0002, 16'h0000},
      {2'd1, 5'h06, 2'd0, 16'h0000, 16'h0004},  // R8
      {2'd0, 5'h04, 2'd1, 16'h0008, 16'h0000},
      {2'd1, 5'h04, 2'd0, 16'h0000, 16'h0000},  // R8
      {2'd0, 5'h08, 2'd2, 16'h0800, 16'h0000},
      {2'd2, 5'h00, 2'd0, 16'd3,    16'h0000},
      {2'd1, 5'h00, 2'd0, 16'h0000, 16'h0007},  // R5
      {2'd1, 5'h08, 2'd0, 16'h0000, 16'h0800}   // R5
   };

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [15:0] d, input logic [1:0] be);
      bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0; bus_be = '0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [15:0] d);
      bus_addr = a; bus_rd = 1'b1;
      #1;
      d = bus_rdata;
      bus_rd = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         tick_en = 1'b1;
         @(posedge clk);
         @(negedge clk);
         tick_en = 1'b0;
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   endtask

   initial begin
      #4_000_000;
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      logic [15:0] d;
      int p0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 reset state
      rd(5'h00, d); check("R11 count", d, 16'h0014);
      rd(5'h12, d); check("R11 start", d, 16'h0014);
      rd(5'h08, d); check("R11 halt", d, 16'h0800);
      rd(5'h04, d); check("R11 flag1", d, 16'h0000);
      rd(5'h06, d); check("R11 flag2", d, 16'h0000);
      rd(5'h0C, d); check("R11 ien", d, 16'h0000);
      check("R11 irq/rst", {14'd0, irq_o, rst_req_o}, 16'h0000);
      ticks(2);
      rd(5'h00, d); check("R5 halted after reset", d, 16'h0014);

      for (int i = 0; i < NV; i++) begin
         logic [1:0]  op;
         logic [4:0]  a;
         logic [1:0]  be;
         logic [15:0] dt, ex;
         {op, a, be, dt, ex} = VEC[i];
         case (op)
            2'd0: wr(a, dt, be);
            2'd1: begin rd(a, d); check($sformatf("table row %0d", i), d, ex); end
            default: ticks(int'(dt));
         endcase
      end

      // R4 boundary: value 4 accepted, 3 rejected
      wr(5'h12, 16'hFC04, 2'd3);
      wr(5'h12, 16'h0003, 2'd1);
      rd(5'h12, d); check("R4 floor", d, 16'hFC04);
      wr(5'h06, 16'h0004, 2'd1);
      rd(5'h06, d); check("R8 boot clear", d, 16'h0000);
      wr(5'h00, 16'h1234, 2'd3);
      wr(5'h08, 16'h0000, 2'd3);

      // R10 interrupt gating
      ticks(5);
      check("R10 irq disabled", {15'd0, irq_o}, 16'd0);
      rd(5'h04, d); check("R6 first flag", d, 16'h0008);
      wr(5'h0C, 16'h2000, 2'd2);
      check("R10 irq enabled", {15'd0, irq_o}, 16'd1);

      // R8 margin restored by clearing before second expiry
      ticks(4);
      wr(5'h04, 16'h0008, 2'd1);
      check("R10 irq follows flag", {15'd0, irq_o}, 16'd0);
      p0 = pulses;
      ticks(1);
      rd(5'h06, d); check("R8 margin flag2", d, 16'h0000);
      rd(5'h04, d); check("R8 margin flag1", d, 16'h0008);
      check("R8 margin no reset", 16'(pulses - p0), 16'd0);

      // R7 reset pulse width
      p0 = pulses;
      ticks(4);
      ticks(1);
      check("R7 reset high", {15'd0, rst_req_o}, 16'd1);
      @(negedge clk);
      check("R7 reset low", {15'd0, rst_req_o}, 16'd0);
      check("R7 one pulse", 16'(pulses - p0), 16'd1);

      // R9 strap blocks reset, flags still move
      no_reboot = 1'b1;
      wr(5'h04, 16'h0008, 2'd1);
      wr(5'h06, 16'h0006, 2'd1);
      p0 = pulses;
      ticks(10);
      rd(5'h06, d); check("R9 flags updated", d, 16'h0006);
      @(negedge clk);
      check("R9 no reset", 16'(pulses - p0), 16'd0);

      finish_run();
   end
endmodule